// File: doc/BRIEF.md
# Bus Slave FIFO Bridge

This block is the slave side of a synchronous master/slave parallel bus. The bus has an 11-bit byte address, a 16-bit data path and active-low select, read strobe and write strobe. The block runs on the bus clock. It answers a small window of even addresses, 0x340 up to 0x34E. A write in the window pushes one bus word into an incoming FIFO. A read in the window pops one word from an outgoing FIFO and drives it onto the bus. During a read the block also turns the external bus transceivers toward the master. An interrupt line tells the master that the outgoing FIFO has data waiting.

The bidirectional data bus is split at the block edge into three signals: an input word, an output word and an output-driver enable. A pad ring or transceiver wrapper joins them. Both FIFOs sit outside the block. They are seen as simple push and pop ports with full and empty flags, and the outgoing FIFO shows its head word while it is not empty. Wait-state generation belongs to the master and is not part of this block.

The control FSM has five states:
- `ST_IDLE`: no access in progress.
- `ST_WR_CAP`: the one-cycle capture of a write.
- `ST_WR_WAIT`: holds after a capture until the write cycle ends.
- `ST_RD_TURN`: turns the bus around, pops the FIFO and latches the word.
- `ST_RD_HOLD`: drives the latched word until the read cycle ends.

Its transitions are:
- `ST_IDLE` to `ST_WR_CAP` on a valid write.
- `ST_IDLE` to `ST_RD_TURN` on a valid read.
- `ST_WR_CAP` to `ST_WR_WAIT` if the write is still valid.
- `ST_RD_TURN` to `ST_RD_HOLD` if the read is still valid.
- `ST_WR_WAIT` and `ST_RD_HOLD` loop back to themselves while the access stays valid.
- Every active state returns to `ST_IDLE` on abort. A write aborts when it is no longer a valid write. A read aborts when it is no longer a valid read.

Top module: `bus_fifo_slave`

## Requirements
- R1: An access is valid only while `cs_n` is 0 and `addr` is even and in 0x340..0x34F. An invalid access never pushes, pops or drives the bus.
- R2: A valid write (`we_n`=0) seen in idle pushes `bus_din` into the incoming FIFO. `in_push` is high for the one clock after the edge that saw the write.
- R3: A write cycle pushes at most once, however long `we_n` stays low. A second push needs a return to idle first.
- R4: A valid read (`oe_n`=0) seen in idle sets `bus_drive_en`=1 and `xcvr_dir`=1 (toward the master) from the next clock. Both stay at 1 until the read ends.
- R5: A read pops the outgoing FIFO exactly once, in the turnaround cycle. The popped word is on `bus_dout` from the following cycle for as long as the read lasts.
- R6: From any active state, the FSM returns to idle at the next edge once `cs_n` rises, the active strobe rises, or `addr` leaves the window.
- R7: In idle and during writes, `bus_drive_en`=0 and `xcvr_dir`=0, and `bus_dout` is 0x0000 outside the read hold state.
- R8: A read while `out_empty`=1 does not pop, and it drives 0x0000.
- R9: A write while `in_full`=1 does not push. It sets `overflow`, which stays at 1 until reset.
- R10: `irq` equals `IRQ_ACTIVE_HIGH` when `out_empty`=0, and its inverse otherwise.
- R11: If `we_n` and `oe_n` are both low in idle, the write takes priority.
- R12: Reset puts the FSM in idle with `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Byte address from master |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| bus_din | input | 16 | Data word from master |
| bus_dout | output | 16 | Data word to master |
| bus_drive_en | output | 1 | Enables the data output driver |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward master |
| in_push | output | 1 | Incoming FIFO push |
| in_data | output | 16 | Incoming FIFO data |
| in_full | input | 1 | Incoming FIFO full |
| out_pop | output | 1 | Outgoing FIFO pop |
| out_data | input | 16 | Outgoing FIFO head word |
| out_empty | input | 1 | Outgoing FIFO empty |
| irq | output | 1 | Data-waiting interrupt |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
Writes are tried at both ends of the window and with the select high. They are also tried at an odd address and just below and just above the window, which separates a correct window decode from an off-by-one or a missing even-address check. Long-held strobes and a write with both strobes low test the one-transfer-per-cycle rule and the write priority. A read aborted during its turnaround cycle shows that the pop happens exactly once and that the bus is released. Reads against a drained FIFO and writes against a full FIFO exercise the zero word, the dropped write and the sticky flag.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_CAP,
        ST_WR_WAIT,
        ST_RD_TURN,
        ST_RD_HOLD
    } bfs_state_e;
endpackage

// File: rtl/bfs_addr_decode.sv
module bfs_addr_decode #(
    parameter int              ADDR_W    = 11,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 11'h340,
    parameter int              WIN_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    output logic              sel
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(WIN_BYTES - 1);

    logic in_window;

    always_comb begin
        in_window = (addr >= BASE_ADDR) && (addr <= LAST_ADDR) && !addr[0];
        sel       = in_window && !cs_n;
    end
endmodule

// File: rtl/bfs_ctrl_fsm.sv
module bfs_ctrl_fsm
    import bfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic wr_req,
    input  logic rd_req,
    input  logic in_full,
    input  logic out_empty,
    output logic in_push,
    output logic out_pop,
    output logic rd_load,
    output logic rd_hold,
    output logic drive_en,
    output logic xcvr_dir,
    output logic overflow
);
    bfs_state_e state, state_nx;
    logic wr_ok, rd_ok;

    always_comb begin
        wr_ok = sel && wr_req;
        rd_ok = sel && rd_req;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_ok)      state_nx = ST_WR_CAP;
                else if (rd_ok) state_nx = ST_RD_TURN;
            end
            ST_WR_CAP:  state_nx = wr_ok ? ST_WR_WAIT : ST_IDLE;
            ST_WR_WAIT: state_nx = wr_ok ? ST_WR_WAIT : ST_IDLE;
            ST_RD_TURN: state_nx = rd_ok ? ST_RD_HOLD : ST_IDLE;
            ST_RD_HOLD: state_nx = rd_ok ? ST_RD_HOLD : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        in_push  = 1'b0;
        out_pop  = 1'b0;
        rd_load  = 1'b0;
        rd_hold  = 1'b0;
        drive_en = 1'b0;
        xcvr_dir = 1'b0;
        unique case (state)
            ST_IDLE, ST_WR_WAIT: ;
            ST_WR_CAP:  in_push = !in_full;
            ST_RD_TURN: begin
                out_pop  = !out_empty;
                rd_load  = 1'b1;
                drive_en = 1'b1;
                xcvr_dir = 1'b1;
            end
            ST_RD_HOLD: begin
                rd_hold  = 1'b1;
                drive_en = 1'b1;
                xcvr_dir = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             overflow <= 1'b0;
        else if (state == ST_WR_CAP && in_full) overflow <= 1'b1;
    end

    AST_ODD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sel) |=> (state == ST_IDLE)); // R1
    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        in_push |=> !in_push); // R3
    AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && rd_ok) |=> drive_en); // R4
    AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        out_pop |=> !out_pop); // R5
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!in_push && !out_pop && !rd_hold)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R9
endmodule

// File: rtl/bfs_irq_gen.sv
module bfs_irq_gen #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic out_empty,
    output logic irq
);
    generate
        if (ACTIVE_HIGH) begin : g_high
            assign irq = !out_empty;
        end else begin : g_low
            assign irq = out_empty;
        end
    endgenerate
endmodule

// File: rtl/bus_fifo_slave.sv
module bus_fifo_slave #(
    parameter int                ADDR_W          = 11,
    parameter int                DATA_W          = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR       = 11'h340,
    parameter int                WIN_BYTES       = 16,
    parameter bit                IRQ_ACTIVE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_drive_en,
    output logic              xcvr_dir,
    output logic              in_push,
    output logic [DATA_W-1:0] in_data,
    input  logic              in_full,
    output logic              out_pop,
    input  logic [DATA_W-1:0] out_data,
    input  logic              out_empty,
    output logic              irq,
    output logic              overflow
);
    logic              sel, rd_load, rd_hold;
    logic [DATA_W-1:0] rd_word;

    bfs_addr_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)
    ) u_dec (
        .addr(addr), .cs_n(cs_n), .sel(sel)
    );

    bfs_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .wr_req(!we_n), .rd_req(!oe_n),
        .in_full(in_full), .out_empty(out_empty),
        .in_push(in_push), .out_pop(out_pop),
        .rd_load(rd_load), .rd_hold(rd_hold),
        .drive_en(bus_drive_en), .xcvr_dir(xcvr_dir),
        .overflow(overflow)
    );

    bfs_irq_gen #(.ACTIVE_HIGH(IRQ_ACTIVE_HIGH)) u_irq (
        .out_empty(out_empty), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_word <= '0;
        else if (rd_load) rd_word <= out_empty ? '0 : out_data;
    end

    assign in_data  = bus_din;
    assign bus_dout = rd_hold ? rd_word : '0;
endmodule

// File: tb/bus_fifo_slave_bench.sv
module bus_fifo_slave_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] bus_din = '0, bus_dout, in_data, out_data = '0;
    logic        bus_drive_en, xcvr_dir, in_push, out_pop, irq, overflow;
    logic        in_full = 1'b0, out_empty = 1'b1;

    int tests = 0, fails = 0;
    logic [15:0] act_in[$], act_out[$], exp_in[$], exp_out[$];
    int          m_st = 0;
    logic        m_ovf = 1'b0;
    logic [15:0] m_rd = '0;

    always #2 clk = ~clk;

    bus_fifo_slave u_bus_fifo_slave (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_drive_en(bus_drive_en),
        .xcvr_dir(xcvr_dir), .in_push(in_push), .in_data(in_data), .in_full(in_full),
        .out_pop(out_pop), .out_data(out_data), .out_empty(out_empty),
        .irq(irq), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic refresh();
        in_full   <= (act_in.size() >= DEPTH);
        out_empty <= (act_out.size() == 0);
        out_data  <= (act_out.size() != 0) ? act_out[0] : 16'h0;
    endtask

    // Bench-side FIFOs, updated at the active edge
    always @(posedge clk) begin
        if (in_push) act_in.push_back(in_data);
        if (out_pop && act_out.size() != 0) void'(act_out.pop_front());
        refresh();
    end

    // Reference model: compare away from the edge, then advance
    always @(negedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ovf = 1'b0; m_rd = '0;
        end else begin
            bit full_e, empty_e, valid, wr_go, rd_go;
            logic [15:0] dout_e;
            full_e  = exp_in.size() >= DEPTH;
            empty_e = exp_out.size() == 0;
            dout_e  = (m_st == 4) ? m_rd : 16'h0;
            chk(in_push == (m_st == 1 && !full_e), "R2 push", {15'h0, in_push}, {15'h0, m_st == 1 && !full_e});
            chk(out_pop == (m_st == 3 && !empty_e), "R5 pop", {15'h0, out_pop}, {15'h0, m_st == 3 && !empty_e});
            chk(bus_drive_en == (m_st >= 3) && xcvr_dir == (m_st >= 3), "R4 drive/dir",
                {14'h0, bus_drive_en, xcvr_dir}, {14'h0, m_st >= 3, m_st >= 3});
            chk(bus_dout == dout_e, "R5 dout", bus_dout, dout_e);
            chk(irq == !empty_e, "R10 irq", {15'h0, irq}, {15'h0, !empty_e});
            chk(overflow == m_ovf, "R9 overflow", {15'h0, overflow}, {15'h0, m_ovf});
            valid = !cs_n && addr >= 11'h340 && addr <= 11'h34F && !addr[0];
            wr_go = valid && !we_n;
            rd_go = valid && !oe_n;
            case (m_st)
                0: m_st = wr_go ? 1 : (rd_go ? 3 : 0);
                1: begin
                    if (full_e) m_ovf = 1'b1; else exp_in.push_back(bus_din);
                    m_st = wr_go ? 2 : 0;
                end
                2: m_st = wr_go ? 2 : 0;
                3: begin
                    if (empty_e) m_rd = 16'h0; else m_rd = exp_out.pop_front();
                    m_st = rd_go ? 4 : 0;
                end
                default: m_st = rd_go ? 4 : 0;
            endcase
        end
    end

    task automatic bus_op(input logic [10:0] a, input logic [15:0] d, input bit wr,
                          input bit rd, input bit cs, input int hold);
        @(posedge clk); #1;
        addr = a; bus_din = d; cs_n = !cs; we_n = !wr; oe_n = !rd;
        repeat (hold) @(posedge clk);
        #1; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic preload(input logic [15:0] d);
        @(posedge clk); #1;
        act_out.push_back(d); exp_out.push_back(d);
        refresh();
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_drive_en && !xcvr_dir && !overflow && !irq, "R12 reset state",
            {12'h0, bus_drive_en, xcvr_dir, overflow, irq}, 16'h0);
        // R2 window ends; R1 ignored accesses
        bus_op(11'h340, 16'hA5A5, 1, 0, 1, 4);
        bus_op(11'h34E, 16'h1234, 1, 0, 1, 3);
        bus_op(11'h342, 16'hDEAD, 1, 0, 0, 3);
        bus_op(11'h341, 16'hBEEF, 1, 0, 1, 3);
        bus_op(11'h350, 16'hCAFE, 1, 0, 1, 3);
        bus_op(11'h33E, 16'hF00D, 1, 0, 1, 3);
        chk(act_in.size() == 2, "R1 ignored writes", 16'(act_in.size()), 16'd2);
        // R11 both strobes low; R3 long hold
        bus_op(11'h346, 16'h0F0F, 1, 1, 1, 3);
        bus_op(11'h348, 16'h5555, 1, 0, 1, 6);
        chk(act_in.size() == 4, "R3 one push per cycle", 16'(act_in.size()), 16'd4);
        // R9 full drops the word, sticky flag
        bus_op(11'h34A, 16'h7777, 1, 0, 1, 3);
        @(negedge clk);
        chk(overflow == 1'b1, "R9 overflow set", {15'h0, overflow}, 16'h1);
        chk(act_in.size() == 4 && act_in[0] == 16'hA5A5 && act_in[1] == 16'h1234 &&
            act_in[2] == 16'h0F0F && act_in[3] == 16'h5555, "R2 captured words",
            (act_in.size() > 3) ? act_in[3] : 16'h0, 16'h5555);
        // R10 irq with data waiting; R4/R5 reads
        preload(16'h1111); preload(16'h2222);
        @(negedge clk);
        chk(irq == 1'b1, "R10 irq when data", {15'h0, irq}, 16'h1);
        bus_op(11'h344, 16'h0, 0, 1, 1, 4);
        bus_op(11'h34C, 16'h0, 0, 1, 1, 5);
        chk(act_out.size() == 0, "R5 one pop per read", 16'(act_out.size()), 16'd0);
        // R8 empty read
        bus_op(11'h340, 16'h0, 0, 1, 1, 3);
        // R1 odd read ignored while data waits
        preload(16'h3333);
        bus_op(11'h345, 16'h0, 0, 1, 1, 3);
        chk(act_out.size() == 1, "R1 odd read no pop", 16'(act_out.size()), 16'd1);
        bus_op(11'h346, 16'h0, 0, 1, 1, 3);
        // R6 abort: address leaves window in turnaround
        preload(16'h4444);
        @(posedge clk); #1;
        addr = 11'h340; cs_n = 1'b0; oe_n = 1'b0;
        @(posedge clk); #1 addr = 11'h360;
        @(posedge clk); #1;
        @(negedge clk);
        chk(!bus_drive_en && bus_dout == 16'h0, "R6 abort releases bus", bus_dout, 16'h0);
        cs_n = 1'b1; oe_n = 1'b1;
        // R7 idle and write keep driver off (model compares every cycle)
        bus_op(11'h340, 16'h9999, 1, 0, 1, 2);
        // R12 reset clears overflow
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(overflow == 1'b0, "R12 overflow cleared", {15'h0, overflow}, 16'h0);
        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule